// File: doc/BRIEF.md
# Capture Sample-Rate Divider and Acquisition Timer

This block paces the sampling of a logic-analyzer capture and keeps track of where that capture stands. From a single base clock it produces a sample-enable strobe. The strobe either passes through a programmable divider or fires on every base cycle when the divider is bypassed. Bypass is also forced whenever an external sampling clock is selected. While a capture runs, the block counts the words written to capture memory and stops itself just short of the memory's end. It also counts elapsed time in units of a fixed number of base cycles.

A start command opens a capture. The block then fills a limited pre-trigger window and waits for a one-cycle trigger pulse that arrives from an external pattern matcher. After the trigger, it keeps writing until the fill threshold is reached. A stop command ends the capture early and leaves both counters frozen so they can still be read out. A small status port returns the fill count, the elapsed duration or the flag word, chosen by a select input.

The duration unit is a fixed count of base cycles. When bypass runs the base clock faster, each unit becomes proportionally shorter: 0.8 of its normal length at a 125/100 clock ratio.

Top module: `smpl_capture_timebase`

## Requirements
- R1: During and after reset, and before any start command, `sample_en` is 0, both counters are 0, triggered is 0, capturing is 0 and memory-available is 1.
- R2: With bypass and external clock both low and `cfg_div` = D > 0, a capture produces `sample_en` in the D-th cycle after the start edge and then once every D+1 base cycles.
- R3: While capturing with `cfg_bypass` or `cfg_ext_clk` high, `sample_en` is 1 in every cycle, whatever the value of `cfg_div`.
- R4: While capturing with `cfg_div` = 0 and no bypass, `sample_en` is 1 in every cycle, the same as bypass.
- R5: `sample_en` is never 1 while capturing is low.
- R6: Before the trigger, each `sample_en` increments the fill count until it equals PRE_WIN, after which the count holds.
- R7: A `trig_pulse` seen while capturing sets triggered at the next edge. Triggered stays set until the next start. A pulse seen while not capturing is ignored.
- R8: Once triggered, every `sample_en` increments the fill count. The edge that brings it to MEM_DEPTH-16 also clears capturing and memory-available, so the count never exceeds that threshold.
- R9: The duration count rises by exactly one after every TICKS_PER_UNIT capturing cycles, independent of divider and bypass settings.
- R10: A stop command clears capturing at the next edge and freezes the fill and duration counts. A sample or trigger pulse in the same cycle as the stop has no effect.
- R11: `stat_data` shows the fill count for `stat_sel`=0, the duration for 1, and for 2 the flags with capturing in bit 0, memory-available in bit 1 and triggered in bit 2 (other bits 0). For `stat_sel`=3 it shows 0.
- R12: A start command, including one issued while a capture is running, clears both counters and triggered, and sets capturing and memory-available. Start takes priority over a stop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command that opens a capture |
| cmd_stop | input | 1 | One-cycle command that ends a capture |
| trig_pulse | input | 1 | One-cycle trigger detection from the pattern matcher |
| cfg_div | input | DIV_W | Divider count: base cycles per sample minus one |
| cfg_bypass | input | 1 | Skip the divider and sample every cycle |
| cfg_ext_clk | input | 1 | External sampling clock selected; forces bypass |
| stat_sel | input | 2 | Status word select |
| sample_en | output | 1 | Sample-enable strobe |
| fill_count | output | 32 | Words written in the current capture |
| dur_count | output | 32 | Elapsed duration units |
| flag_triggered | output | 1 | Trigger has been seen (sticky) |
| flag_mem_avail | output | 1 | Capture memory still has room |
| flag_capturing | output | 1 | Capture in progress |
| stat_data | output | 32 | Selected status word |

## Verification
The main coincidences are a stop command landing in the same cycle as a sample strobe or a trigger pulse, and a start landing on top of a stop. Both are provoked by directed sequences under bypass, where every capturing cycle carries a strobe. They also arise in a long random run with sparse command pulses. A per-cycle reference model in the bench applies the stated priorities, start over stop and stop over sample and trigger, and compares its result with every counter and flag at the following falling edge. The threshold edge, where the last write and the capture shutdown happen together, is reached repeatedly with small divider values.

// File: rtl/smpl_pkg.sv
package smpl_pkg;

    localparam int STAT_W        = 32;
    localparam int FILL_HEADROOM = 16;

    typedef struct packed {
        logic triggered;
        logic mem_avail;
        logic capturing;
    } cap_flags_t;

    typedef enum logic [1:0] {
        SEL_FILL  = 2'd0,
        SEL_DUR   = 2'd1,
        SEL_FLAGS = 2'd2,
        SEL_NONE  = 2'd3
    } stat_sel_e;

    function automatic logic [STAT_W-1:0] flags_word(input cap_flags_t f);
        return {{(STAT_W-3){1'b0}}, f};
    endfunction

endpackage

// File: rtl/smpl_rate_div.sv
module smpl_rate_div #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             bypass,
    input  logic [DIV_W-1:0] div,
    output logic             sen
);
    logic [DIV_W-1:0] cnt;
    logic             every;
    logic             wrap;

    assign every = bypass || (div == '0);
    assign wrap  = every || (cnt >= div);
    assign sen   = run && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            if (wrap) cnt <= '0;
            else      cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smpl_dur_timer.sv
module smpl_dur_timer #(
    parameter int TICKS_PER_UNIT = 100000,
    parameter int DUR_W          = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic [DUR_W-1:0] dur
);
    localparam int TICK_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_UNIT - 1);

    logic [TICK_W-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tick <= '0;
            dur  <= '0;
        end else if (run) begin
            if (tick == LAST_TICK) begin
                tick <= '0;
                dur  <= dur + 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smpl_fill_ctrl.sv
module smpl_fill_ctrl
    import smpl_pkg::*;
#(
    parameter int FILL_W      = 32,
    parameter int FILL_THRESH = 4080,
    parameter int PRE_WIN     = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              trig,
    input  logic              sen,
    output logic [FILL_W-1:0] fill,
    output cap_flags_t        flags
);
    localparam logic [FILL_W-1:0] LAST_WORD = FILL_W'(FILL_THRESH - 1);
    localparam logic [FILL_W-1:0] PRE_LIMIT = FILL_W'(PRE_WIN);

    logic may_write;
    logic wr;

    assign may_write = flags.triggered || (fill < PRE_LIMIT);
    assign wr        = sen && may_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill  <= '0;
            flags <= '{triggered: 1'b0, mem_avail: 1'b1, capturing: 1'b0};
        end else if (start) begin
            fill  <= '0;
            flags <= '{triggered: 1'b0, mem_avail: 1'b1, capturing: 1'b1};
        end else if (stop) begin
            flags.capturing <= 1'b0;
        end else if (flags.capturing) begin
            if (trig) flags.triggered <= 1'b1;
            if (wr) begin
                fill <= fill + 1'b1;
                if (fill == LAST_WORD) begin
                    flags.capturing <= 1'b0;
                    flags.mem_avail <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/smpl_capture_timebase.sv
module smpl_capture_timebase
    import smpl_pkg::*;
#(
    parameter int DIV_W          = 32,
    parameter int MEM_DEPTH      = 4096,
    parameter int PRE_WIN        = 256,
    parameter int TICKS_PER_UNIT = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             trig_pulse,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_bypass,
    input  logic             cfg_ext_clk,
    input  logic [1:0]       stat_sel,
    output logic             sample_en,
    output logic [31:0]      fill_count,
    output logic [31:0]      dur_count,
    output logic             flag_triggered,
    output logic             flag_mem_avail,
    output logic             flag_capturing,
    output logic [31:0]      stat_data
);
    localparam int FILL_THRESH = MEM_DEPTH - FILL_HEADROOM;

    cap_flags_t flags;
    logic       bypass_eff;
    logic       run;

    assign bypass_eff = cfg_bypass || cfg_ext_clk;
    assign run        = flags.capturing && !cmd_stop;

    smpl_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd_start),
        .run     (flags.capturing),
        .bypass  (bypass_eff),
        .div     (cfg_div),
        .sen     (sample_en)
    );

    smpl_dur_timer #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .DUR_W(32)) u_dur (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd_start),
        .run   (run),
        .dur   (dur_count)
    );

    smpl_fill_ctrl #(.FILL_W(32), .FILL_THRESH(FILL_THRESH), .PRE_WIN(PRE_WIN)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .start (cmd_start),
        .stop  (cmd_stop),
        .trig  (trig_pulse),
        .sen   (sample_en),
        .fill  (fill_count),
        .flags (flags)
    );

    assign flag_triggered = flags.triggered;
    assign flag_mem_avail = flags.mem_avail;
    assign flag_capturing = flags.capturing;

    always_comb begin
        case (stat_sel_e'(stat_sel))
            SEL_FILL:  stat_data = fill_count;
            SEL_DUR:   stat_data = dur_count;
            SEL_FLAGS: stat_data = flags_word(flags);
            default:   stat_data = '0;
        endcase
    end
endmodule

// File: rtl/smpl_capture_chk.sv
module smpl_capture_chk #(
    parameter int FILL_THRESH = 4080
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_start,
    input logic        cmd_stop,
    input logic        cfg_bypass,
    input logic        cfg_ext_clk,
    input logic        sample_en,
    input logic [31:0] fill_count,
    input logic [31:0] dur_count,
    input logic        flag_triggered,
    input logic        flag_mem_avail,
    input logic        flag_capturing
);
    AST_SEN_ONLY_CAPTURING: assert property (@(posedge clk) disable iff (rst) sample_en |-> flag_capturing); // R5
    AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst) (flag_capturing && (cfg_bypass || cfg_ext_clk)) |-> sample_en); // R3
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst) fill_count <= 32'(FILL_THRESH)); // R8
    AST_FULL_STOPS: assert property (@(posedge clk) disable iff (rst) !flag_mem_avail |-> !flag_capturing); // R8
    AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (rst) (flag_triggered && !cmd_start) |=> flag_triggered); // R7
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst) (cmd_stop && !cmd_start) |=> !flag_capturing); // R10
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst) (cmd_stop && !cmd_start) |=> ($stable(fill_count) && $stable(dur_count))); // R10
    AST_DUR_STEP: assert property (@(posedge clk) disable iff (rst) !cmd_start |=> ((dur_count == $past(dur_count)) || (dur_count == $past(dur_count) + 32'd1))); // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) cmd_start |=> (fill_count == 32'd0 && dur_count == 32'd0 && flag_capturing && flag_mem_avail && !flag_triggered)); // R12
endmodule

bind smpl_capture_timebase smpl_capture_chk #(.FILL_THRESH(FILL_THRESH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_start      (cmd_start),
    .cmd_stop       (cmd_stop),
    .cfg_bypass     (cfg_bypass),
    .cfg_ext_clk    (cfg_ext_clk),
    .sample_en      (sample_en),
    .fill_count     (fill_count),
    .dur_count      (dur_count),
    .flag_triggered (flag_triggered),
    .flag_mem_avail (flag_mem_avail),
    .flag_capturing (flag_capturing)
);

// File: tb/sim_smpl_capture_timebase.sv
module sim_smpl_capture_timebase;
    localparam int DIV_W  = 8;
    localparam int DEPTH  = 64;
    localparam int PRE    = 8;
    localparam int TICKS  = 20;
    localparam int THRESH = DEPTH - 16;

    logic clk = 1'b0;
    logic rst, cmd_start, cmd_stop, trig_pulse, cfg_bypass, cfg_ext_clk;
    logic [DIV_W-1:0] cfg_div;
    logic [1:0]  stat_sel;
    logic        sample_en, flag_triggered, flag_mem_avail, flag_capturing;
    logic [31:0] fill_count, dur_count, stat_data;

    always #2 clk = ~clk;

    smpl_capture_timebase #(.DIV_W(DIV_W), .MEM_DEPTH(DEPTH), .PRE_WIN(PRE), .TICKS_PER_UNIT(TICKS)) u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .trig_pulse(trig_pulse),
        .cfg_div(cfg_div), .cfg_bypass(cfg_bypass), .cfg_ext_clk(cfg_ext_clk), .stat_sel(stat_sel),
        .sample_en(sample_en), .fill_count(fill_count), .dur_count(dur_count),
        .flag_triggered(flag_triggered), .flag_mem_avail(flag_mem_avail),
        .flag_capturing(flag_capturing), .stat_data(stat_data)
    );

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // reference state
    bit m_cap, m_trig, m_avail;
    int m_fill, m_dur, m_tick, m_div;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic bit exp_sen();
        return m_cap && (cfg_bypass || cfg_ext_clk || cfg_div == 0 || m_div >= int'(cfg_div));
    endfunction

    function automatic logic [31:0] exp_stat();
        case (stat_sel)
            2'd0: return 32'(m_fill);
            2'd1: return 32'(m_dur);
            2'd2: return {29'd0, m_trig, m_avail, m_cap};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        bit sen;
        sen = exp_sen();
        if (rst) begin
            m_cap = 0; m_trig = 0; m_avail = 1; m_fill = 0; m_dur = 0; m_tick = 0; m_div = 0;
        end else if (cmd_start) begin
            m_cap = 1; m_trig = 0; m_avail = 1; m_fill = 0; m_dur = 0; m_tick = 0; m_div = 0;
        end else if (cmd_stop) begin
            m_cap = 0;
        end else if (m_cap) begin
            bit old_trig;
            old_trig = m_trig;
            if (cfg_bypass || cfg_ext_clk || cfg_div == 0 || m_div >= int'(cfg_div)) m_div = 0;
            else m_div++;
            if (trig_pulse) m_trig = 1;
            if (sen && (old_trig || m_fill < PRE)) begin
                m_fill++;
                if (m_fill == THRESH) begin m_cap = 0; m_avail = 0; end
            end
            if (m_tick == TICKS - 1) begin m_tick = 0; m_dur++; end
            else m_tick++;
        end
    endtask

    task automatic check_all();
        string st;
        if (!m_cap) st = "R5";
        else if (cfg_bypass || cfg_ext_clk) st = "R3";
        else if (cfg_div == 0) st = "R4";
        else st = "R2";
        chk(st, 32'(sample_en), 32'(exp_sen()));
        chk(m_trig ? "R8" : "R6", fill_count, 32'(m_fill));
        chk("R9", dur_count, 32'(m_dur));
        chk("R7", 32'(flag_triggered), 32'(m_trig));
        chk("R8", 32'(flag_mem_avail), 32'(m_avail));
        chk("R10", 32'(flag_capturing), 32'(m_cap));
        chk("R11", stat_data, exp_stat());
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
        cmd_start = 0; cmd_stop = 0; trig_pulse = 0; rst = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1; cmd_start = 0; cmd_stop = 0; trig_pulse = 0;
        cfg_div = 3; cfg_bypass = 0; cfg_ext_clk = 0; stat_sel = 0;
        @(negedge clk);
        step(); rst = 1; step(); rst = 1; step();
        // R1: reset state
        chk("R1", {sample_en, flag_triggered, flag_mem_avail, flag_capturing}, 4'b0010);
        chk("R1", fill_count | dur_count, 32'd0);
        run(5);

        // R2: divider 3, first strobe 3 cycles after start, then every 4
        cfg_div = 3; cmd_start = 1; step();
        chk("R2", 32'(sample_en), 32'd0); step(); step();
        chk("R2", 32'(sample_en), 32'd0); step();
        chk("R2", 32'(sample_en), 32'd1);
        run(40);
        chk("R6", fill_count, 32'(PRE));
        trig_pulse = 1; step();
        chk("R7", 32'(flag_triggered), 32'd1);
        run(250);
        chk("R8", fill_count, 32'(THRESH));
        chk("R8", 32'(flag_capturing), 32'd0);
        trig_pulse = 1; step();
        chk("R7", 32'(flag_triggered), 32'd1);

        // R3, R10: bypass; stop together with trigger and sample
        cfg_bypass = 1; cfg_div = 5; cmd_start = 1; step();
        run(30);
        cmd_stop = 1; trig_pulse = 1; step();
        chk("R10", 32'(flag_triggered), 32'd0);
        chk("R10", fill_count, 32'(PRE));
        stat_sel = 1; run(25);
        chk("R10", dur_count, 32'd1);

        // R4 with external clock select, and restart while running (R12)
        cfg_bypass = 0; cfg_div = 0; stat_sel = 2; cmd_start = 1; step();
        trig_pulse = 1; run(20);
        cfg_ext_clk = 1; cfg_div = 4; run(10);
        cmd_start = 1; cmd_stop = 1; step();
        chk("R12", {fill_count[3:0], 1'b0, flag_triggered, flag_mem_avail, flag_capturing}, 8'h03);
        chk("R12", dur_count, 32'd0);
        cfg_ext_clk = 0;
        run(60);

        // random phase
        for (int i = 0; i < 9000; i++) begin
            int r;
            r = $urandom % 1000;
            cmd_start  = (r < 4);
            cmd_stop   = (r >= 4 && r < 7);
            trig_pulse = ($urandom % 50) == 0;
            stat_sel   = 2'($urandom % 4);
            if (!m_cap && ($urandom % 8) == 0) begin
                cfg_div     = DIV_W'($urandom % 6);
                cfg_bypass  = ($urandom % 4) == 0;
                cfg_ext_clk = ($urandom % 6) == 0;
            end
            step();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule